// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Multistage Network

This block moves up to N packets per clock from N input lines to N output lines. It passes them through log2(N) stages of two-by-two switch elements. Ahead of every stage the lines are permuted by a perfect shuffle. Each packet steers itself: every switch reads one bit of the packet's destination and sends the packet either up or down. Each packet has exactly one path through the network. When two packets in a switch need the same output, one of them cannot proceed. That packet is dropped, and a blocked flag is raised for its source. No retry or buffering takes place inside the network.

Every stage ends in a register. A set of packets presented together leaves the network log2(N) cycles later. In the same cycle, a blocked flag appears for each dropped packet. A new set of packets can be presented on every cycle. Each delivered packet carries its payload and the index of the input it entered on, so a client can see which permutation the network realised.

Top module: `omega_network`

## Requirements
- R1: A packet presented with its valid high at clock edge k appears at its output at edge k+log2(N). Packets presented on consecutive cycles travel independently of each other.
- R2: Before each stage, the packet on line i moves to the line whose index is i rotated left by one bit within log2(N) bits. The identity pattern (destination i for input i) therefore reaches every output with no blocking. So does every cyclic shift (destination (i+c) mod N).
- R3: The first stage uses the most significant destination bit and the last stage uses the least significant bit. A bit of 0 selects the upper output of a switch (even line) and a bit of 1 selects the lower output (odd line). A packet that is not blocked leaves on the output whose index equals its destination.
- R4: A delivered output carries the packet's W-bit payload unchanged on out_data, and on out_src it carries the log2(N)-bit index of the input the packet entered on.
- R5: When both packets at a switch are valid and select the same output, the packet on the upper (even) input line goes on. The packet on the lower input line is removed and does not reach any output.
- R6: A removed packet raises in_blocked at the bit of its original input index, with the same latency as R1, for one cycle. A packet that is delivered never has its in_blocked bit set.
- R7: An input whose valid is low produces no output. It never causes another packet to be blocked.
- R8: While rst_n is low, out_valid and in_blocked are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-input packet present |
| in_dest | input | N*log2(N) | Destination of input i in bits [i*log2(N) +: log2(N)] |
| in_data | input | N*W | Payload of input i in bits [i*W +: W] |
| out_valid | output | N | Per-output packet delivered |
| out_data | output | N*W | Payload on output j in bits [j*W +: W] |
| out_src | output | N*log2(N) | Source index on output j in bits [j*log2(N) +: log2(N)] |
| in_blocked | output | N | Bit i is set when the packet from input i was dropped |

## Verification
A fault in a shuffle connection or in a switch's bit selection shows up log2(N) cycles after the vector is presented. The packet then appears on the wrong output, or a conflict is reported where the requirements predict none. A fault in the arbitration or the blocked bookkeeping shows up in the same cycle as the wrong source on a contended output: either a blocked bit set on the winner, or two packets lost where only one should be. A pipeline register that is not cleared by reset shows as a stray out_valid or in_blocked during reset.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Rotate an index left by one place within nb bits (perfect shuffle).
  function automatic int unsigned shuffle_dst(int unsigned idx, int unsigned nb);
    int unsigned mask;
    mask = (32'd1 << nb) - 32'd1;
    return ((idx << 1) | (idx >> (nb - 1))) & mask;
  endfunction

  // Destination bit consumed by a given stage: MSB first.
  function automatic int unsigned stage_bit(int unsigned stage, int unsigned nb);
    return nb - 1 - stage;
  endfunction

  // Width of one packet word on an internal line: valid, dest, src, payload.
  function automatic int unsigned pkt_width(int unsigned nb, int unsigned w);
    return 1 + 2 * nb + w;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int LOGN = 3,
  parameter int W    = 8,
  parameter int DBIT = 2,
  localparam int PW  = omega_pkg::pkt_width(LOGN, W)
) (
  input  logic [PW-1:0]   up_pkt,
  input  logic [PW-1:0]   lo_pkt,
  output logic [PW-1:0]   up_out,
  output logic [PW-1:0]   lo_out,
  output logic            drop_vld,
  output logic [LOGN-1:0] drop_src
);
  localparam int VB   = PW - 1;
  localparam int DLO  = LOGN + W;
  localparam int SLO  = W;

  logic up_v, lo_v, up_b, lo_b, clash, lo_go;

  always_comb begin
    up_v  = up_pkt[VB];
    lo_v  = lo_pkt[VB];
    up_b  = up_pkt[DLO + DBIT];
    lo_b  = lo_pkt[DLO + DBIT];
    clash = up_v && lo_v && (up_b == lo_b);
    lo_go = lo_v && !clash;
  end

  always_comb begin
    up_out = '0;
    lo_out = '0;
    if (up_v) begin
      if (up_b) lo_out = up_pkt;
      else      up_out = up_pkt;
    end
    if (lo_go) begin
      if (lo_b) lo_out = lo_pkt;
      else      up_out = lo_pkt;
    end
  end

  assign drop_vld = clash;
  assign drop_src = lo_pkt[SLO +: LOGN];

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N     = 8,
  parameter int LOGN  = 3,
  parameter int W     = 8,
  parameter int STAGE = 0,
  localparam int PW   = omega_pkg::pkt_width(LOGN, W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*PW-1:0] in_bus,
  input  logic [N-1:0]    in_blk,
  output logic [N*PW-1:0] out_bus,
  output logic [N-1:0]    out_blk
);
  localparam int HALF = N / 2;
  localparam int DBIT = int'(omega_pkg::stage_bit(STAGE, LOGN));
  localparam int VB   = PW - 1;
  localparam int DLO  = LOGN + W;

  logic [N*PW-1:0]      shuf;
  logic [N*PW-1:0]      sw_bus;
  logic [HALF-1:0]      drop_v;
  logic [HALF*LOGN-1:0] drop_s;
  logic [N-1:0]         new_blk;

  // Observation wires for the checks below
  logic [N-1:0]         v_in, v_sw, v_q, b_q;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int J = int'(omega_pkg::shuffle_dst(i, LOGN));
    assign shuf[J*PW +: PW] = in_bus[i*PW +: PW];
    assign v_in[i] = in_bus[i*PW + VB];
    assign v_sw[i] = sw_bus[i*PW + VB];
    assign v_q[i]  = out_bus[i*PW + VB];
    assign b_q[i]  = out_bus[i*PW + DLO + DBIT];
  end

  for (genvar k = 0; k < HALF; k++) begin : g_sw
    omega_switch #(.LOGN(LOGN), .W(W), .DBIT(DBIT)) u_sw (
      .up_pkt   (shuf[(2*k)*PW +: PW]),
      .lo_pkt   (shuf[(2*k+1)*PW +: PW]),
      .up_out   (sw_bus[(2*k)*PW +: PW]),
      .lo_out   (sw_bus[(2*k+1)*PW +: PW]),
      .drop_vld (drop_v[k]),
      .drop_src (drop_s[k*LOGN +: LOGN])
    );
  end

  always_comb begin
    new_blk = '0;
    for (int k = 0; k < HALF; k++) begin
      if (drop_v[k]) new_blk[drop_s[k*LOGN +: LOGN]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bus <= '0;
      out_blk <= '0;
    end else begin
      out_bus <= sw_bus;
      out_blk <= in_blk | new_blk;
    end
  end

  // Every valid packet entering the stage either leaves on a line or is dropped (R5).
  assert_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_in) == $countones(v_sw) + $countones(drop_v));

  // A registered packet sits on the line parity its stage bit selected (R3).
  for (genvar j = 0; j < N; j++) begin : g_chk
    assert_line_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[j] |-> (b_q[j] == ((j % 2) == 1)));
  end

endmodule

// File: rtl/omega_network.sv
module omega_network #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int LOGN = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*LOGN-1:0] in_dest,
  input  logic [N*W-1:0]    in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*W-1:0]    out_data,
  output logic [N*LOGN-1:0] out_src,
  output logic [N-1:0]      in_blocked
);
  localparam int PW  = omega_pkg::pkt_width(LOGN, W);
  localparam int VB  = PW - 1;
  localparam int DLO = LOGN + W;
  localparam int SLO = W;

  logic [N*PW-1:0] bus [0:LOGN];
  logic [N-1:0]    blk [0:LOGN];

  for (genvar i = 0; i < N; i++) begin : g_in
    localparam logic [LOGN-1:0] SRC = LOGN'(i);
    assign bus[0][i*PW +: PW] = in_valid[i]
      ? {1'b1, in_dest[i*LOGN +: LOGN], SRC, in_data[i*W +: W]}
      : '0;
  end
  assign blk[0] = '0;

  for (genvar s = 0; s < LOGN; s++) begin : g_stage
    omega_stage #(.N(N), .LOGN(LOGN), .W(W), .STAGE(s)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_bus  (bus[s]),
      .in_blk  (blk[s]),
      .out_bus (bus[s+1]),
      .out_blk (blk[s+1])
    );
  end

  logic [N*LOGN-1:0] fin_dest;

  for (genvar j = 0; j < N; j++) begin : g_out
    assign out_valid[j]              = bus[LOGN][j*PW + VB];
    assign out_data[j*W +: W]        = bus[LOGN][j*PW +: W];
    assign out_src[j*LOGN +: LOGN]   = bus[LOGN][j*PW + SLO +: LOGN];
    assign fin_dest[j*LOGN +: LOGN]  = bus[LOGN][j*PW + DLO +: LOGN];
  end
  assign in_blocked = blk[LOGN];

  // Sources that reached some output this cycle
  logic [N-1:0] delivered;
  always_comb begin
    delivered = '0;
    for (int j = 0; j < N; j++) begin
      if (out_valid[j]) delivered[out_src[j*LOGN +: LOGN]] = 1'b1;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    localparam logic [LOGN-1:0] LINE = LOGN'(j);
    // A delivered packet leaves on the line named by its destination (R3).
    assert_route_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (fin_dest[j*LOGN +: LOGN] == LINE));
    // A source is never both delivered and reported blocked (R6).
    assert_blk_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(delivered[j] && in_blocked[j]));
  end

endmodule

// File: tb/omega_network_test.sv
module omega_network_test;
  localparam int N = 8;
  localparam int W = 8;
  localparam int LOGN = $clog2(N);
  localparam time CLKP = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N*LOGN-1:0] in_dest = '0;
  logic [N*W-1:0]    in_data = '0;
  logic [N-1:0]      out_valid;
  logic [N*W-1:0]    out_data;
  logic [N*LOGN-1:0] out_src;
  logic [N-1:0]      in_blocked;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLKP/2) clk = ~clk;

  omega_network #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .in_blocked(in_blocked)
  );

  // Stimulus vector
  logic            v_vld [N];
  logic [LOGN-1:0] v_dst [N];
  logic [W-1:0]    v_dat [N];
  // Expected results, two slots for back-to-back vectors
  logic            e_vld [2][N];
  logic [W-1:0]    e_dat [2][N];
  logic [LOGN-1:0] e_src [2][N];
  logic            e_blk [2][N];

  // Reference: position after stage s is the low bits of the source shifted
  // up with the first s+1 destination bits appended below.
  task automatic predict(input int slot);
    bit alive [N];
    int prev [N];
    int pos [N];
    bit lose [N];
    for (int i = 0; i < N; i++) begin
      alive[i] = v_vld[i]; prev[i] = i;
      e_vld[slot][i] = 1'b0; e_dat[slot][i] = '0; e_src[slot][i] = '0;
      e_blk[slot][i] = 1'b0;
    end
    for (int s = 0; s < LOGN; s++) begin
      for (int i = 0; i < N; i++) begin
        pos[i] = ((i << (s+1)) | (int'(v_dst[i]) >> (LOGN-1-s))) & (N-1);
        lose[i] = 1'b0;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && alive[i] && alive[j] && pos[i] == pos[j]
              && ((prev[i] >> (LOGN-1)) & 1) == 1)
            lose[i] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (lose[i]) begin alive[i] = 1'b0; e_blk[slot][i] = 1'b1; end
        prev[i] = pos[i];
      end
    end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin
        e_vld[slot][v_dst[i]] = 1'b1;
        e_dat[slot][v_dst[i]] = v_dat[i];
        e_src[slot][v_dst[i]] = LOGN'(i);
      end
  endtask

  task automatic drive_vec();
    for (int i = 0; i < N; i++) begin
      in_valid[i] = v_vld[i];
      in_dest[i*LOGN +: LOGN] = v_dst[i];
      in_data[i*W +: W] = v_dat[i];
    end
  endtask

  task automatic compare(input int slot, input string rq);
    for (int j = 0; j < N; j++) begin
      n_chk++;
      if (out_valid[j] !== e_vld[slot][j] ||
          (e_vld[slot][j] && (out_data[j*W +: W] !== e_dat[slot][j] ||
                              out_src[j*LOGN +: LOGN] !== e_src[slot][j]))) begin
        n_bad++;
        $display("FAIL %s out%0d: actual v=%b d=%h s=%0d expected v=%b d=%h s=%0d", rq, j,
          out_valid[j], out_data[j*W +: W], out_src[j*LOGN +: LOGN],
          e_vld[slot][j], e_dat[slot][j], e_src[slot][j]);
      end
    end
    for (int i = 0; i < N; i++) begin
      n_chk++;
      if (in_blocked[i] !== e_blk[slot][i]) begin
        n_bad++;
        $display("FAIL %s blocked%0d: actual %b expected %b", rq, i, in_blocked[i], e_blk[slot][i]);
      end
    end
  endtask

  // Present one vector for one cycle, sample after LOGN edges (R1).
  task automatic run_one(input string rq);
    @(negedge clk);
    drive_vec();
    predict(0);
    @(negedge clk);
    in_valid = '0;
    repeat (LOGN-1) @(negedge clk);
    compare(0, rq);
    // One cycle later everything must have drained (single-cycle pulses, R6).
    @(negedge clk);
    n_chk++;
    if (out_valid !== '0 || in_blocked !== '0) begin
      n_bad++;
      $display("FAIL R6 drain: actual v=%b b=%b expected 0", out_valid, in_blocked);
    end
  endtask

  task automatic t_reset();
    #(CLKP*2);
    n_chk++;
    if (out_valid !== '0 || in_blocked !== '0) begin
      n_bad++;
      $display("FAIL R8 reset: actual v=%b b=%b expected 0", out_valid, in_blocked);
    end
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_identity();
    for (int i = 0; i < N; i++) begin
      v_vld[i] = 1'b1; v_dst[i] = LOGN'(i); v_dat[i] = W'(8'hA0 + i);
    end
    run_one("R2 identity");
  endtask

  task automatic t_shift(input int c);
    for (int i = 0; i < N; i++) begin
      v_vld[i] = 1'b1; v_dst[i] = LOGN'((i + c) % N); v_dat[i] = W'(8'h30 + i*3 + c);
    end
    run_one("R2 R3 R4 cyclic shift");
  endtask

  task automatic t_conflict_pair();
    // Inputs 0 and 4 both to 0: meet at switch 0 of the first stage, input 0 upper.
    for (int i = 0; i < N; i++) begin v_vld[i] = 1'b0; v_dst[i] = '0; v_dat[i] = '0; end
    v_vld[0] = 1'b1; v_dat[0] = 8'h11;
    v_vld[4] = 1'b1; v_dat[4] = 8'h44;
    run_one("R5 R6 pair conflict");
    n_chk++;
    if (!(e_blk[0][4] && !e_blk[0][0])) begin
      n_bad++;
      $display("FAIL R5 model: actual blk4=%b blk0=%b expected 1 0", e_blk[0][4], e_blk[0][0]);
    end
  endtask

  task automatic t_hotspot();
    for (int i = 0; i < N; i++) begin
      v_vld[i] = 1'b1; v_dst[i] = 3'd5; v_dat[i] = W'(8'hC0 + i);
    end
    run_one("R5 R6 all to one output");
  endtask

  task automatic t_idle();
    // Input 4 would collide with 0 if it were valid; with valid low it must not.
    for (int i = 0; i < N; i++) begin v_vld[i] = 1'b0; v_dst[i] = '0; v_dat[i] = 8'hFF; end
    v_vld[0] = 1'b1; v_dat[0] = 8'h5A;
    v_vld[6] = 1'b1; v_dst[6] = 3'd3; v_dat[6] = 8'h66;
    run_one("R7 idle inputs");
  endtask

  task automatic t_mixed();
    int d [N] = '{3, 3, 7, 0, 1, 6, 6, 2};
    for (int i = 0; i < N; i++) begin
      v_vld[i] = (i != 5); v_dst[i] = LOGN'(d[i]); v_dat[i] = W'(8'h71 ^ (i*13));
    end
    run_one("R3 R5 mixed");
  endtask

  task automatic t_stream();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      v_vld[i] = 1'b1; v_dst[i] = LOGN'(N-1-i); v_dat[i] = W'(8'h90 + i);
    end
    drive_vec(); predict(0);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      v_vld[i] = 1'b1; v_dst[i] = LOGN'(i/2); v_dat[i] = W'(8'h20 + i);
    end
    drive_vec(); predict(1);
    @(negedge clk);
    in_valid = '0;
    repeat (LOGN-2) @(negedge clk);
    compare(0, "R1 stream first");
    @(negedge clk);
    compare(1, "R1 stream second");
    @(negedge clk);
  endtask

  initial begin
    #(CLKP*100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_identity();
    t_shift(1);
    t_shift(5);
    t_conflict_pair();
    t_hotspot();
    t_idle();
    t_mixed();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule